// File: doc/BRIEF.md
# Vector Element Order Reverser

This unit takes one 128-bit vector operand and rearranges its elements. The vector is split into containers of 16, 32 or 64 bits. Inside each container the order of the elements is reversed, with elements of 8, 16 or 32 bits. The bits inside an element are never changed; only whole elements move.

The caller supplies the operand, a container-size code, an element-size code, a full/half selector and a one-cycle `in_valid` strobe. One clock later the unit raises `out_valid` for one cycle. At the same time it presents the rearranged vector and a flag that marks a size pairing with no defined meaning. In half mode only the low 64 bits take part, and the upper 64 bits of the result are zero. An undefined pairing gives an all-zero result with the flag set, and `out_valid` still pulses.

Internally, a decoder turns the two size codes into a legality bit and a 3-bit byte-index XOR mask. A byte crossbar applies that mask. A single result register stage holds the output.

Top module: `simd_elem_rev`

## Requirements
- R1: With container code 2 (64-bit containers), element code 0 (byte) reverses 8 bytes per container, code 1 (halfword) reverses 4 halfwords, and code 2 (word) swaps the 2 words.
- R2: With container code 1 (32-bit containers), element code 0 reverses 4 bytes per container and code 1 swaps the 2 halfwords.
- R3: With container code 0 (16-bit containers), element code 0 swaps the two bytes of every halfword.
- R4: The illegal cases are: element code 3 with container code 2; element codes 2 and 3 with container code 1; element codes 1 to 3 with container code 0; and container code 3 with any element code. For these, `out_illegal` is 1 and `out_vec` is zero. For every other case `out_illegal` is 0.
- R5: When `in_full` is 0, only bytes 0 to 7 are rearranged and `out_vec[127:64]` is zero. When `in_full` is 1, all 16 bytes take part.
- R6: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1. The result and the flag for that request appear in the same cycle.
- R7: While `rst` is high at a clock edge, `out_valid`, `out_vec` and `out_illegal` become 0.
- R8: A cycle with `in_valid` low leaves `out_vec` and `out_illegal` unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_vec | input | 128 | Source vector, byte 0 in bits [7:0] |
| in_cont | input | 2 | Container size: 0=16, 1=32, 2=64 bits, 3=reserved |
| in_esz | input | 2 | Element size: 0=8, 1=16, 2=32, 3=64 bits |
| in_full | input | 1 | 1 = full 128 bits, 0 = low 64 bits only |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | 128 | Rearranged vector |
| out_illegal | output | 1 | Undefined size pairing |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector of 8-bit lanes, which gives a 16-byte crossbar with two 64-bit halves. That width covers every container and element pairing, both in full mode and in half mode, including the case where the upper half must be zeroed.

A fixed-seed random stream covers all sixteen code pairs with random operands. Directed cases use a counting byte pattern, so that a lane placed at the wrong position shows up at once.

// File: rtl/simd_rev_pkg.sv
package simd_rev_pkg;

    localparam int LANE_W = 8;
    localparam int XMASK_W = 3;

    typedef enum logic [1:0] {
        CONT_16   = 2'd0,
        CONT_32   = 2'd1,
        CONT_64   = 2'd2,
        CONT_RSVD = 2'd3
    } cont_e;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_e;

    typedef struct packed {
        logic                 legal;
        logic [XMASK_W-1:0]   xmask;
    } swap_ctl_t;

endpackage

// File: rtl/simd_rev_decode.sv
module simd_rev_decode
    import simd_rev_pkg::*;
(
    input  logic [1:0] cont_code,
    input  logic [1:0] esz_code,
    output swap_ctl_t  ctl
);

    cont_e cont;
    esz_e  esz;

    assign cont = cont_e'(cont_code);
    assign esz  = esz_e'(esz_code);

    // Byte XOR mask equals container bytes minus element bytes.
    always_comb begin
        ctl = '0;
        unique case (cont)
            CONT_64: begin
                unique case (esz)
                    ESZ_8:   ctl = '{legal: 1'b1, xmask: 3'd7};
                    ESZ_16:  ctl = '{legal: 1'b1, xmask: 3'd6};
                    ESZ_32:  ctl = '{legal: 1'b1, xmask: 3'd4};
                    default: ctl = '0;
                endcase
            end
            CONT_32: begin
                unique case (esz)
                    ESZ_8:   ctl = '{legal: 1'b1, xmask: 3'd3};
                    ESZ_16:  ctl = '{legal: 1'b1, xmask: 3'd2};
                    default: ctl = '0;
                endcase
            end
            CONT_16: begin
                if (esz == ESZ_8) ctl = '{legal: 1'b1, xmask: 3'd1};
                else              ctl = '0;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/simd_rev_xbar.sv
module simd_rev_xbar
    import simd_rev_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   src,
    input  logic [XMASK_W-1:0] xmask,
    input  logic               keep_hi,
    output logic [VEC_W-1:0]   dst
);

    localparam int NLANE = VEC_W / LANE_W;
    localparam int IDX_W = $clog2(NLANE);
    localparam int HALF  = NLANE / 2;

    logic [LANE_W-1:0] lane [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_split
        assign lane[g] = src[g*LANE_W +: LANE_W];
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_pick
        localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
        logic [IDX_W-1:0] from;
        assign from = SELF ^ IDX_W'(xmask);
        if (g >= HALF) begin : g_hi
            assign dst[g*LANE_W +: LANE_W] = keep_hi ? lane[from] : '0;
        end else begin : g_lo
            assign dst[g*LANE_W +: LANE_W] = lane[from];
        end
    end

endmodule

// File: rtl/simd_elem_rev.sv
module simd_elem_rev
    import simd_rev_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic [1:0]       in_cont,
    input  logic [1:0]       in_esz,
    input  logic             in_full,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_illegal
);

    localparam int HALF_W = VEC_W / 2;

    swap_ctl_t        ctl;
    logic [VEC_W-1:0] permuted;
    logic [VEC_W-1:0] next_vec;

    simd_rev_decode u_dec (
        .cont_code (in_cont),
        .esz_code  (in_esz),
        .ctl       (ctl)
    );

    simd_rev_xbar #(.VEC_W(VEC_W)) u_xbar (
        .src     (in_vec),
        .xmask   (ctl.xmask),
        .keep_hi (in_full),
        .dst     (permuted)
    );

    assign next_vec = ctl.legal ? permuted : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_vec     <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec     <= next_vec;
                out_illegal <= ~ctl.legal;
            end
        end
    end

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_illegal_zero_r4: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_vec == '0));
    p_half_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_full) |=> (out_vec[VEC_W-1:HALF_W] == '0));
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_vec) && $stable(out_illegal)));

endmodule

// File: tb/simd_elem_rev_test.sv
module simd_elem_rev_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_vec = '0;
    logic [1:0]   in_cont = '0;
    logic [1:0]   in_esz = '0;
    logic         in_full = 1'b0;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_elem_rev uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .in_cont(in_cont), .in_esz(in_esz), .in_full(in_full),
        .out_valid(out_valid), .out_vec(out_vec), .out_illegal(out_illegal)
    );

    function automatic bit ref_illegal(input logic [1:0] c, input logic [1:0] e);
        int cb;
        int eb;
        cb = (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 0;
        eb = 1 << e;
        return (c == 2'd3) || (eb >= cb);
    endfunction

    function automatic logic [127:0] ref_vec(input logic [127:0] s, input logic [1:0] c,
                                             input logic [1:0] e, input logic f);
        logic [127:0] r;
        int cb;
        int eb;
        int ne;
        int k;
        r = '0;
        if (ref_illegal(c, e)) return r;
        cb = (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
        eb = 1 << e;
        ne = (f ? 16 : 8) / eb;
        k  = cb / eb - 1;
        for (int i = 0; i < ne; i++)
            for (int b = 0; b < eb; b++)
                r[(i*eb + b)*8 +: 8] = s[((i ^ k)*eb + b)*8 +: 8];
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input string tag, input logic [127:0] s, input logic [1:0] c,
                           input logic [1:0] e, input logic f);
        logic [127:0] ev;
        bit           ei;
        ev = ref_vec(s, c, e, f);
        ei = ref_illegal(c, e);
        @(negedge clk);
        in_vec = s; in_cont = c; in_esz = e; in_full = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_vec = {$urandom, $urandom, $urandom, $urandom};
        in_cont = 2'($urandom); in_esz = 2'($urandom); in_full = 1'($urandom);
        check({tag, " R6 valid"}, 128'(out_valid), 128'd1);
        check({tag, " result"}, out_vec, ev);
        check({tag, " R4 flag"}, 128'(out_illegal), 128'(ei));
        @(negedge clk);
        check({tag, " R6 single pulse"}, 128'(out_valid), 128'd0);
        check({tag, " R8 hold"}, out_vec, ev);
        check({tag, " R8 flag hold"}, 128'(out_illegal), 128'(ei));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        for (int n = 0; n < 100000; n++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [127:0] ramp;
        for (int i = 0; i < 16; i++) ramp[i*8 +: 8] = 8'(i);
        void'($urandom(32'h5eed_1234));
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset valid", 128'(out_valid), 128'd0);
        check("R7 reset vec", out_vec, '0);
        check("R7 reset flag", 128'(out_illegal), 128'd0);
        in_valid = 1'b0;
        rst = 1'b0;

        // R1 hand-computed expectation on the counting pattern
        @(negedge clk);
        in_vec = ramp; in_cont = 2'd2; in_esz = 2'd0; in_full = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 byte rev 64", out_vec, 128'h08090a0b0c0d0e0f_0001020304050607);

        run_one("R1 half in 64", ramp, 2'd2, 2'd1, 1'b1);
        run_one("R1 word in 64", ramp, 2'd2, 2'd2, 1'b1);
        run_one("R2 byte in 32", ramp, 2'd1, 2'd0, 1'b1);
        run_one("R2 half in 32", ramp, 2'd1, 2'd1, 1'b1);
        run_one("R3 byte in 16", ramp, 2'd0, 2'd0, 1'b1);
        run_one("R5 half mode byte 64", ramp, 2'd2, 2'd0, 1'b0);
        run_one("R5 half mode byte 16", ramp, 2'd0, 2'd0, 1'b0);
        run_one("R4 dword in 64", ramp, 2'd2, 2'd3, 1'b1);
        run_one("R4 word in 32", ramp, 2'd1, 2'd2, 1'b1);
        run_one("R4 half in 16", ramp, 2'd0, 2'd1, 1'b1);
        run_one("R4 reserved cont", ramp, 2'd3, 2'd0, 1'b1);

        for (int n = 0; n < 300; n++) begin
            run_one("random R1 R2 R3 R4 R5",
                    {$urandom, $urandom, $urandom, $urandom},
                    2'($urandom), 2'($urandom), 1'($urandom));
        end
        finish_run();
    end

endmodule